// File: doc/BRIEF.md
# Unsigned Multiply-Add with Split Double-Width Result

The block takes three unsigned word operands, multiplies the first two at full double width, and adds the third after padding it with zeros to double width. The double-width sum is handed back as two word results: the lower word and the upper word. The sum never exceeds double width, because the largest product plus the largest addend is still below 2^(2W). Nothing is truncated, and no flag is produced.

A one-cycle `start` pulse captures all three operands. The result is built by a shift-add sequencer that retires `STEP` multiplier bits per cycle. With `STEP` = 2 that is a radix-4 sequencer taking W/2 cycles. When the result is ready, `done` pulses for one cycle. Both result words then hold their values until the next operation completes. A `start` that arrives while an operation is running is dropped.

Top module: `mac_split`

## Requirements
- R1: The product of `op_a` and `op_b` is formed at full 2W-bit width, so all-ones operands with a zero addend return upper word 2^W-2 and lower word 1.
- R2: `op_c` is zero-extended to 2W bits before the addition, so a zero product with an all-ones addend returns upper word 0 and lower word all ones.
- R3: `res_lo` carries bits W-1..0 of op_a*op_b+op_c.
- R4: `res_hi` carries bits 2W-1..W of op_a*op_b+op_c. All three operands at all ones give upper word all ones and lower word 0.
- R5: `done` is high for exactly one cycle. It rises W/STEP clock cycles after the edge that accepts `start`, which is 32 cycles with the default parameters.
- R6: `res_lo` and `res_hi` change only at the edge that raises `done`, and they hold their values while idle.
- R7: A `start` seen while an operation is running has no effect. It does not alter the running result and produces no later `done`.
- R8: While `rst_n` is low, and after its release, `done` is 0 and both result words are 0 until the first operation completes.
- R9: Operands are captured only at the accepting edge. Changing `op_a`, `op_b` or `op_c` afterwards does not affect the result.
- R10: A `start` in the same cycle that `done` is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation and capture the operands |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| op_c | input | W | Addend, zero-extended |
| res_lo | output | W | Lower word of the sum |
| res_hi | output | W | Upper word of the sum |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a sum whose carries ripple through every bit of both words. This happens when all three operands are all ones, so the final partial product pushes a carry from the addend's low bits into the top of the upper word. The bench drives that case directly. It also drives the two edge cases on either side of it: a full product with no addend, and an addend with a zero product. A mix of patterned operands then exercises the middle bits. The busy-ignore case, and a restart issued in the exact cycle of `done`, both depend on the cycle timing, so the bench counts cycles from the accepting edge before it raises `start`.

// File: rtl/mac_split.sv
module mac_split #(
  parameter int W    = 64,
  parameter int STEP = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi,
  output logic         done
);
  localparam int N  = W / STEP;
  localparam int CW = $clog2(N + 1);

  logic           busy;
  logic           accept;
  logic [CW-1:0]  cnt;
  logic [2*W-1:0] acc, mcand, pp, acc_nx;
  logic [W-1:0]   mplier;

  assign accept = start & ~busy;

  always_comb begin
    pp = '0;
    for (int i = 0; i < STEP; i++)
      if (mplier[i]) pp = pp + (mcand << i);
  end

  assign acc_nx = acc + pp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      res_lo <= '0;
      res_hi <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        acc    <= {{W{1'b0}}, op_c};
        mcand  <= {{W{1'b0}}, op_a};
        mplier <= op_b;
        cnt    <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        acc    <= acc_nx;
        mcand  <= mcand << STEP;
        mplier <= mplier >> STEP;
        if (cnt == CW'(N - 1)) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          res_lo <= acc_nx[W-1:0];
          res_hi <= acc_nx[2*W-1:W];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mac_split_chk.sv
module mac_split_chk #(
  parameter int W    = 64,
  parameter int STEP = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] op_c,
  input logic [W-1:0] res_lo,
  input logic [W-1:0] res_hi,
  input logic         done
);
  localparam int N  = W / STEP;
  localparam int LW = $clog2(N + 2);

  logic [W-1:0]  ca, cb, cc;
  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca <= '0; cb <= '0; cc <= '0; lat <= '0;
    end else if (start && !busy) begin
      ca <= op_a; cb <= op_b; cc <= op_c; lat <= '0;
    end else if (busy) begin
      lat <= lat + 1'b1;
    end
  end

  // R1 R2 R3 R4: completed result matches a double-width reference
  assert_sum_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({res_hi, res_lo} == ({{W{1'b0}}, ca} * {{W{1'b0}}, cb} + {{W{1'b0}}, cc})));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == LW'(N)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({res_hi, res_lo}));

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && lat != LW'(N - 1)) |=> (busy && !done));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind mac_split mac_split_chk #(.W(W), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .op_a(op_a), .op_b(op_b), .op_c(op_c),
  .res_lo(res_lo), .res_hi(res_hi), .done(done)
);

// File: tb/sim_mac_split.sv
`timescale 1ns/1ps
module sim_mac_split;
  localparam int W = 64;
  localparam int STEP = 2;
  localparam int N = W / STEP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
  logic [W-1:0] res_lo, res_hi;
  logic done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mac_split #(.W(W), .STEP(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .res_lo(res_lo), .res_hi(res_hi), .done(done)
  );

  function automatic logic [2*W-1:0] ref_sum(input logic [W-1:0] a, b, c);
    logic [2*W-1:0] p;
    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    return p + {{W{1'b0}}, c};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [2*W-1:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive start at a negedge, returns cycles until done is seen
  task automatic launch(input logic [W-1:0] a, b, c, output int lat);
    op_a = a; op_b = b; op_c = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_a = ~a; op_b = b ^ 64'h5a5a; op_c = ~c;   // R9: must not matter
    lat = 1;
    while (!done && lat < 4 * N) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, b, c, input string req);
    int lat;
    logic [2*W-1:0] e;
    e = ref_sum(a, b, c);
    launch(a, b, c, lat);
    chk(lat == N + 1, "R5 latency", 128'(lat), 128'(N + 1));
    chk(res_lo == e[W-1:0], {req, " R3 low word"}, 128'(res_lo), 128'(e[W-1:0]));
    chk(res_hi == e[2*W-1:W], {req, " R4 high word"}, 128'(res_hi), 128'(e[2*W-1:W]));
    @(negedge clk);
    chk(done == 1'b0, "R5 single pulse", 128'(done), 128'(0));
    chk({res_hi, res_lo} == e, "R6 hold after done", {res_hi, res_lo}, e);
  endtask

  task automatic t_reset;
    chk(done == 1'b0, "R8 done in reset", 128'(done), 128'(0));
    chk({res_hi, res_lo} == '0, "R8 results in reset", {res_hi, res_lo}, '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R8 done after release", 128'(done), 128'(0));
    chk({res_hi, res_lo} == '0, "R8 results after release", {res_hi, res_lo}, '0);
  endtask

  task automatic t_corners;
    run_op('1, '1, '0, "R1 full product");
    chk(res_hi == 64'hFFFF_FFFF_FFFF_FFFE && res_lo == 64'd1, "R1 constants",
        {res_hi, res_lo}, {64'hFFFF_FFFF_FFFF_FFFE, 64'd1});
    run_op('0, '1, '1, "R2 zero-extended addend");
    chk(res_hi == '0 && res_lo == '1, "R2 constants", {res_hi, res_lo}, {64'd0, {64{1'b1}}});
    run_op('1, '1, '1, "R4 full carry");
    chk(res_hi == '1 && res_lo == '0, "R4 constants", {res_hi, res_lo}, {{64{1'b1}}, 64'd0});
    run_op(64'd0, 64'd0, 64'd0, "R3 all zero");
    run_op(64'd1, 64'd1, 64'd0, "R3 unit");
  endtask

  task automatic t_mixed;
    logic [W-1:0] s = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] a, b, c;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17); a = s;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17); b = s;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17); c = s;
      run_op(a, b, c, "R3 R4 mixed");
    end
    run_op(64'h8000_0000_0000_0000, 64'd2, 64'd7, "R4 bit crossing");
  endtask

  task automatic t_busy_ignore;
    logic [2*W-1:0] e;
    int lat;
    e = ref_sum(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'h42);
    op_a = 64'h1234_5678_9ABC_DEF0; op_b = 64'h0FED_CBA9_8765_4321; op_c = 64'h42;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    op_a = '1; op_b = '1; op_c = '1; start = 1'b1;   // R7: while running
    @(negedge clk); start = 1'b0;
    lat = 7;
    while (!done && lat < 4 * N) begin @(negedge clk); lat++; end
    chk(lat == N + 1, "R7 latency unchanged", 128'(lat), 128'(N + 1));
    chk({res_hi, res_lo} == e, "R7 result from first op", {res_hi, res_lo}, e);
    lat = 0;
    for (int k = 0; k < N + 6; k++) begin @(negedge clk); if (done) lat++; end
    chk(lat == 0, "R7 no extra done", 128'(lat), 128'(0));
    chk({res_hi, res_lo} == e, "R6 idle hold", {res_hi, res_lo}, e);
  endtask

  task automatic t_restart_on_done;
    logic [2*W-1:0] e1, e2;
    int lat;
    e1 = ref_sum(64'd3, 64'd5, 64'd11);
    e2 = ref_sum(64'hDEAD_BEEF, 64'hCAFE_F00D_0000_0001, 64'h77);
    launch(64'd3, 64'd5, 64'd11, lat);
    chk({res_hi, res_lo} == e1, "R10 first result", {res_hi, res_lo}, e1);
    launch(64'hDEAD_BEEF, 64'hCAFE_F00D_0000_0001, 64'h77, lat);  // start while done is high
    chk(lat == N + 1, "R10 restart latency", 128'(lat), 128'(N + 1));
    chk({res_hi, res_lo} == e2, "R10 restart result", {res_hi, res_lo}, e2);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_corners();
    t_mixed();
    t_busy_ignore();
    t_restart_on_done();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule